// File: doc/BRIEF.md
# Half-Line Progressive Video Timing Generator

This block produces the line and frame timing for one progressive, PAL-style raster. A horizontal counter runs in pixel clocks. A vertical counter runs in half-lines, and it advances twice on every line. Every horizontal event is set as an offset from the leading edge of horizontal sync. Every vertical region is set as a length in half-lines. The block decodes both counters into one packed byte of active-low sync and burst flags and a separate active-video qualifier. A downstream pixel source or encoder reads them on every clock.

The timing values come in on plain input ports. The generator copies them into internal registers on every clock while the synchronous reset is high, and ignores them at all other times. The pixel-clock enable gates all counting, so the outputs hold while the enable is low.

The vertical order starting at half-line 0 is as follows:
1. A burst-blank band of E half-lines, where E is the equalisation length.
2. A vertical sync band of E half-lines.
3. A second burst-blank band of E half-lines.
4. The pre-blank band.
5. The active lines, two half-lines each.
6. The rest of the frame, up to the programmed total, which forms the post-blank band.

Top module: `hlt_timing_gen`

## Requirements
- R1: While reset is high the counters clear. After reset falls, and before the first enabled edge, sync_flags equals 8'h2B with PAL_MODE=1, and active_q is 0.
- R2: The horizontal position advances on each enabled clock and wraps to 0 after 2*cfg_half_width positions. The half-line count advances on the enabled clock at positions cfg_half_width-1 and 2*cfg_half_width-1.
- R3: The horizontal sync flag, bit 4, is 0 exactly while the horizontal position is below cfg_hsync_width.
- R4: The burst flag, bit 3, is 0 on every line while the horizontal position p satisfies cfg_burst_start <= p < cfg_burst_end.
- R5: With E = cfg_equ_halves and half-line count v, the burst-blank flag, bit 2, is 0 while v < 3*E. The vertical sync flag, bit 5, is 0 while E <= v < 2*E.
- R6: The composite sync flag, bit 7, is the AND of bits 5 and 4, so it is 0 whenever either sync flag is 0.
- R7: active_q is 1 exactly when both of these hold. First, v lies in [3*E + cfg_preblank_halves, 3*E + cfg_preblank_halves + 2*cfg_active_lines). Second, the horizontal position p satisfies cfg_hblank_end <= p < cfg_half_width + cfg_hblank_start.
- R8: The half-line count wraps from cfg_frame_halves-1 to 0.
- R9: The field flag, bit 6, is always 0. The standard flag, bit 1, equals PAL_MODE. The interlace flag, bit 0, is always 1, which marks progressive scan.
- R10: Timing inputs that change while reset is low have no effect. The values present during reset are used until the next reset.
- R11: While pix_en is low, sync_flags and active_q do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high; timing inputs are captured while it is high |
| pix_en | input | 1 | Pixel-clock enable |
| cfg_half_width | input | HW | Half-line length in clocks |
| cfg_hsync_width | input | HW | Horizontal sync width |
| cfg_burst_start | input | HW | Burst start offset from sync start |
| cfg_burst_end | input | HW | Burst end offset from sync start |
| cfg_hblank_end | input | HW | Horizontal blank end offset |
| cfg_hblank_start | input | HW | Horizontal blank start, counted into the second half-line |
| cfg_frame_halves | input | VW | Frame length in half-lines |
| cfg_equ_halves | input | VW | Length of each vertical blanking band in half-lines |
| cfg_preblank_halves | input | VW | Pre-blank length in half-lines |
| cfg_active_lines | input | VW | Active region length in full lines |
| sync_flags | output | 8 | Flags, bit 7 to 0: csync_n, field, vsync_n, hsync_n, burst_n, bblank_n, pal, progressive |
| active_q | output | 1 | Active-video qualifier |

## Verification
The bench builds the block with its default widths, HW=11, VW=11 and PAL_MODE=1. These widths hold the full-size raster of 864-clock lines and 1250 half-lines, so the bench can run about 47 full-size lines, up to and into the first active line. The bench also uses two small rasters, with 40-clock and 32-clock lines, of 18 and 11 half-lines. With those it reaches frame wraps within a few hundred clocks, and it covers an odd frame total, which shifts line starts across half-lines. It also covers irregular enable patterns, and timing inputs that change while the generator is running.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

  // Bit positions of the packed flag byte; downstream logic decodes these.
  localparam int FLAG_C = 7;
  localparam int FLAG_F = 6;
  localparam int FLAG_V = 5;
  localparam int FLAG_H = 4;
  localparam int FLAG_B = 3;
  localparam int FLAG_K = 2;
  localparam int FLAG_N = 1;
  localparam int FLAG_I = 0;

  typedef struct packed {
    logic csync_n;
    logic field;
    logic vsync_n;
    logic hsync_n;
    logic burst_n;
    logic bblank_n;
    logic std_pal;
    logic progressive;
  } flags_t;

  // Half-open window test: lo <= v < hi.
  function automatic logic in_span(input logic [15:0] v,
                                   input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (v >= lo) && (v < hi);
  endfunction

  // Three equal blanking bands back to back.
  function automatic logic [15:0] vblank_len(input logic [15:0] equ);
    return (equ << 1) + equ;
  endfunction

endpackage

// File: rtl/hlt_hcount.sv
module hlt_hcount #(
  parameter int HW = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pix_en,
  input  logic [HW-1:0] half_w,
  output logic [HW:0] hcnt,
  output logic        half_tick
);
  localparam logic [HW:0] ONE = (HW+1)'(1);

  logic [HW:0] line_last;
  logic [HW:0] mid_last;
  logic        at_mid;
  logic        at_end;

  assign line_last = {half_w, 1'b0} - ONE;
  assign mid_last  = {1'b0, half_w} - ONE;
  assign at_mid    = (hcnt == mid_last);
  assign at_end    = (hcnt == line_last);
  assign half_tick = pix_en && (at_mid || at_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
    end else if (pix_en) begin
      hcnt <= at_end ? '0 : hcnt + ONE;
    end
  end

  // R2
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt <= line_last);

  // R2
  hcnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && at_end) |=> (hcnt == '0));

  // R11
  hcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(hcnt));

endmodule

// File: rtl/hlt_vcount.sv
module hlt_vcount #(
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          half_tick,
  input  logic [VW-1:0] frame_halves,
  input  logic [VW-1:0] equ_halves,
  input  logic [VW-1:0] pre_halves,
  input  logic [VW-1:0] act_lines,
  output logic [VW-1:0] vcnt,
  output logic          vs_zone,
  output logic          bb_zone,
  output logic          line_act
);
  import hlt_pkg::*;

  localparam int EW = VW + 2;
  localparam logic [VW-1:0] ONE = VW'(1);

  logic [VW-1:0] v_last;
  logic          at_last;
  logic [EW-1:0] e1, e2, e3, a0, a1, vc;

  assign v_last  = frame_halves - ONE;
  assign at_last = (vcnt == v_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt <= '0;
    end else if (half_tick) begin
      vcnt <= at_last ? '0 : vcnt + ONE;
    end
  end

  assign vc = EW'(vcnt);
  assign e1 = EW'(equ_halves);
  assign e2 = {1'b0, equ_halves, 1'b0};
  assign e3 = EW'(vblank_len(16'(equ_halves)));
  assign a0 = e3 + EW'(pre_halves);
  assign a1 = a0 + EW'({act_lines, 1'b0});

  assign bb_zone  = 16'(vc) < 16'(e3);
  assign vs_zone  = in_span(16'(vc), 16'(e1), 16'(e2));
  assign line_act = in_span(16'(vc), 16'(a0), 16'(a1));

  // R8
  vcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    vcnt < frame_halves);

  // R8
  vcnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (half_tick && at_last) |=> (vcnt == '0));

  // R2
  vcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(vcnt));

endmodule

// File: rtl/hlt_hdecode.sv
module hlt_hdecode #(
  parameter int HW = 11
) (
  input  logic [HW:0]   hcnt,
  input  logic [HW-1:0] half_w,
  input  logic [HW-1:0] hsync_w,
  input  logic [HW-1:0] burst_start,
  input  logic [HW-1:0] burst_end,
  input  logic [HW-1:0] hblank_end,
  input  logic [HW-1:0] hblank_start,
  output logic          hs_zone,
  output logic          burst_zone,
  output logic          pix_act
);
  import hlt_pkg::*;

  logic [HW:0] blank_from;

  // Blank start is counted from the second half-line.
  assign blank_from = {1'b0, half_w} + {1'b0, hblank_start};

  assign hs_zone    = 16'(hcnt) < 16'(hsync_w);
  assign burst_zone = in_span(16'(hcnt), 16'(burst_start), 16'(burst_end));
  assign pix_act    = in_span(16'(hcnt), 16'(hblank_end), 16'(blank_from));

endmodule

// File: rtl/hlt_flagpack.sv
module hlt_flagpack #(
  parameter bit PAL_MODE = 1'b1
) (
  input  logic       hs_zone,
  input  logic       vs_zone,
  input  logic       burst_zone,
  input  logic       bb_zone,
  input  logic       line_act,
  input  logic       pix_act,
  output logic [7:0] flags,
  output logic       active
);
  import hlt_pkg::*;

  flags_t f;

  always_comb begin
    f.hsync_n     = ~hs_zone;
    f.vsync_n     = ~vs_zone;
    f.csync_n     = f.hsync_n & f.vsync_n;
    f.field       = 1'b0;
    f.burst_n     = ~burst_zone;
    f.bblank_n    = ~bb_zone;
    f.std_pal     = PAL_MODE;
    f.progressive = 1'b1;
  end

  assign flags  = f;
  assign active = line_act & pix_act;

endmodule

// File: rtl/hlt_timing_gen.sv
module hlt_timing_gen #(
  parameter int HW       = 11,
  parameter int VW       = 11,
  parameter bit PAL_MODE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic [HW-1:0] cfg_half_width,
  input  logic [HW-1:0] cfg_hsync_width,
  input  logic [HW-1:0] cfg_burst_start,
  input  logic [HW-1:0] cfg_burst_end,
  input  logic [HW-1:0] cfg_hblank_end,
  input  logic [HW-1:0] cfg_hblank_start,
  input  logic [VW-1:0] cfg_frame_halves,
  input  logic [VW-1:0] cfg_equ_halves,
  input  logic [VW-1:0] cfg_preblank_halves,
  input  logic [VW-1:0] cfg_active_lines,
  output logic [7:0]    sync_flags,
  output logic          active_q
);
  import hlt_pkg::*;

  logic [HW-1:0] sh_half_w, sh_hsync_w, sh_bst, sh_bend, sh_hbe, sh_hbs;
  logic [VW-1:0] sh_total, sh_equ, sh_pre, sh_act;

  // Timing settings are taken only while the generator is held in reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_half_w  <= cfg_half_width;
      sh_hsync_w <= cfg_hsync_width;
      sh_bst     <= cfg_burst_start;
      sh_bend    <= cfg_burst_end;
      sh_hbe     <= cfg_hblank_end;
      sh_hbs     <= cfg_hblank_start;
      sh_total   <= cfg_frame_halves;
      sh_equ     <= cfg_equ_halves;
      sh_pre     <= cfg_preblank_halves;
      sh_act     <= cfg_active_lines;
    end
  end

  logic [HW:0]   hcnt;
  logic [VW-1:0] vcnt;
  logic          half_tick;
  logic          hs_zone, burst_zone, pix_act;
  logic          vs_zone, bb_zone, line_act;

  hlt_hcount #(.HW(HW)) hcount_i (
    .clk       (clk),
    .rst       (rst),
    .pix_en    (pix_en),
    .half_w    (sh_half_w),
    .hcnt      (hcnt),
    .half_tick (half_tick)
  );

  hlt_vcount #(.VW(VW)) vcount_i (
    .clk          (clk),
    .rst          (rst),
    .half_tick    (half_tick),
    .frame_halves (sh_total),
    .equ_halves   (sh_equ),
    .pre_halves   (sh_pre),
    .act_lines    (sh_act),
    .vcnt         (vcnt),
    .vs_zone      (vs_zone),
    .bb_zone      (bb_zone),
    .line_act     (line_act)
  );

  hlt_hdecode #(.HW(HW)) hdecode_i (
    .hcnt         (hcnt),
    .half_w       (sh_half_w),
    .hsync_w      (sh_hsync_w),
    .burst_start  (sh_bst),
    .burst_end    (sh_bend),
    .hblank_end   (sh_hbe),
    .hblank_start (sh_hbs),
    .hs_zone      (hs_zone),
    .burst_zone   (burst_zone),
    .pix_act      (pix_act)
  );

  hlt_flagpack #(.PAL_MODE(PAL_MODE)) flagpack_i (
    .hs_zone    (hs_zone),
    .vs_zone    (vs_zone),
    .burst_zone (burst_zone),
    .bb_zone    (bb_zone),
    .line_act   (line_act),
    .pix_act    (pix_act),
    .flags      (sync_flags),
    .active     (active_q)
  );

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable({sh_half_w, sh_hsync_w, sh_bst, sh_bend, sh_hbe, sh_hbs,
                      sh_total, sh_equ, sh_pre, sh_act}));

  // R6
  csync_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_flags[FLAG_H] || !sync_flags[FLAG_V]) |-> !sync_flags[FLAG_C]);

  // R7
  active_clear_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (sync_flags[FLAG_K] && sync_flags[FLAG_V]));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(sync_flags) && $stable(active_q)));

endmodule

// File: tb/hlt_timing_gen_tb_top.sv
module hlt_timing_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HW = 11;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic [HW-1:0] cfg_half_width, cfg_hsync_width, cfg_burst_start;
  logic [HW-1:0] cfg_burst_end, cfg_hblank_end, cfg_hblank_start;
  logic [VW-1:0] cfg_frame_halves, cfg_equ_halves, cfg_preblank_halves, cfg_active_lines;
  logic [7:0] sync_flags;
  logic       active_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  hlt_timing_gen #(.HW(HW), .VW(VW), .PAL_MODE(1'b1)) dut_i (
    .clk                 (clk),
    .rst                 (rst),
    .pix_en              (pix_en),
    .cfg_half_width      (cfg_half_width),
    .cfg_hsync_width     (cfg_hsync_width),
    .cfg_burst_start     (cfg_burst_start),
    .cfg_burst_end       (cfg_burst_end),
    .cfg_hblank_end      (cfg_hblank_end),
    .cfg_hblank_start    (cfg_hblank_start),
    .cfg_frame_halves    (cfg_frame_halves),
    .cfg_equ_halves      (cfg_equ_halves),
    .cfg_preblank_halves (cfg_preblank_halves),
    .cfg_active_lines    (cfg_active_lines),
    .sync_flags          (sync_flags),
    .active_q            (active_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference timing values (what the bench believes is loaded).
  int m_hlw, m_hsy, m_hcs, m_hce, m_hbe, m_hbs, m_tot, m_equ, m_pre, m_acv;
  int m_h, m_v;
  logic [7:0] prev_flags;
  logic       prev_act;
  int h_falls, k_falls, first_act;
  int cyc_idx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (h=%0d v=%0d)", req, act, exp, m_h, m_v);
    end
  endtask

  task automatic drive_cfg(input int hlw, input int hsy, input int hcs, input int hce,
                           input int hbe, input int hbs, input int tot, input int equ,
                           input int pre, input int acv);
    cfg_half_width      = HW'(hlw);
    cfg_hsync_width     = HW'(hsy);
    cfg_burst_start     = HW'(hcs);
    cfg_burst_end       = HW'(hce);
    cfg_hblank_end      = HW'(hbe);
    cfg_hblank_start    = HW'(hbs);
    cfg_frame_halves    = VW'(tot);
    cfg_equ_halves      = VW'(equ);
    cfg_preblank_halves = VW'(pre);
    cfg_active_lines    = VW'(acv);
  endtask

  task automatic latch_model();
    m_hlw = int'(cfg_half_width);   m_hsy = int'(cfg_hsync_width);
    m_hcs = int'(cfg_burst_start);  m_hce = int'(cfg_burst_end);
    m_hbe = int'(cfg_hblank_end);   m_hbs = int'(cfg_hblank_start);
    m_tot = int'(cfg_frame_halves); m_equ = int'(cfg_equ_halves);
    m_pre = int'(cfg_preblank_halves); m_acv = int'(cfg_active_lines);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pix_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    latch_model();
    m_h = 0;
    m_v = 0;
  endtask

  task automatic advance();
    if (m_h == m_hlw - 1 || m_h == 2*m_hlw - 1)
      m_v = (m_v == m_tot - 1) ? 0 : m_v + 1;
    m_h = (m_h == 2*m_hlw - 1) ? 0 : m_h + 1;
  endtask

  task automatic compare_all(input bit last_en);
    bit hs, vs, bu, bb, la, pa, ea;
    hs = m_h < m_hsy;
    vs = (m_v >= m_equ) && (m_v < 2*m_equ);
    bu = (m_h >= m_hcs) && (m_h < m_hce);
    bb = m_v < 3*m_equ;
    la = (m_v >= 3*m_equ + m_pre) && (m_v < 3*m_equ + m_pre + 2*m_acv);
    pa = (m_h >= m_hbe) && (m_h < m_hlw + m_hbs);
    ea = la && pa;
    chk(sync_flags[4] == !hs, "R3 hsync flag", int'(sync_flags[4]), int'(!hs));
    chk(sync_flags[3] == !bu, "R4 burst flag", int'(sync_flags[3]), int'(!bu));
    chk(sync_flags[2] == !bb, "R5 burst-blank flag", int'(sync_flags[2]), int'(!bb));
    chk(sync_flags[5] == !vs, "R5 vsync flag", int'(sync_flags[5]), int'(!vs));
    chk(sync_flags[7] == !(hs || vs), "R6 csync flag", int'(sync_flags[7]), int'(!(hs || vs)));
    chk(sync_flags[6] == 1'b0 && sync_flags[1:0] == 2'b11, "R9 constant flags",
        int'({sync_flags[6], sync_flags[1:0]}), 3);
    chk(active_q == ea, "R7 active qualifier", int'(active_q), int'(ea));
    if (!last_en)
      chk(sync_flags == prev_flags && active_q == prev_act, "R11 hold while disabled",
          int'({active_q, sync_flags}), int'({prev_act, prev_flags}));
    if (prev_flags[4] && !sync_flags[4]) h_falls++;
    if (prev_flags[2] && !sync_flags[2]) k_falls++;
    if (active_q && first_act < 0) first_act = cyc_idx;
    prev_flags = sync_flags;
    prev_act = active_q;
  endtask

  // pat 0: enable always high; pat 1: enable low one clock in three.
  task automatic run(input int n, input int pat);
    bit last_en;
    last_en = 1'b1;
    prev_flags = sync_flags;
    prev_act = active_q;
    h_falls = 0;
    k_falls = 0;
    first_act = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_idx = i;
      compare_all(last_en);
      pix_en = (pat == 0) ? 1'b1 : ((i % 3) != 1);
      last_en = pix_en;
      @(posedge clk);
      if (pix_en) advance();
    end
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic t_reset();
    drive_cfg(20, 4, 5, 8, 10, 15, 18, 2, 4, 3);
    do_reset();
    chk(sync_flags == 8'h2B, "R1 flags after reset", int'(sync_flags), 32'h2B);
    chk(active_q == 1'b0, "R1 active after reset", int'(active_q), 0);
  endtask

  task automatic t_small_frames();
    drive_cfg(20, 4, 5, 8, 10, 15, 18, 2, 4, 3);
    do_reset();
    run(720, 0);
    chk(h_falls == 17, "R2 line period (hsync starts in two frames)", h_falls, 17);
    chk(k_falls == 1, "R8 frame wrap (burst-blank restarts)", k_falls, 1);
  endtask

  task automatic t_odd_frame_stall();
    drive_cfg(16, 3, 4, 6, 7, 12, 11, 1, 3, 2);
    do_reset();
    run(800, 1);
    chk(k_falls >= 1, "R8 odd-total frame wrap seen", k_falls, 1);
  endtask

  task automatic t_cfg_ignore();
    drive_cfg(20, 4, 5, 8, 10, 15, 18, 2, 4, 3);
    do_reset();
    run(100, 0);
    drive_cfg(16, 3, 4, 6, 7, 12, 11, 1, 3, 2);
    run(500, 0);
    chk(h_falls == 12, "R10 old line length kept after input change", h_falls, 12);
    do_reset();
    chk(m_hlw == 16, "R10 new settings taken at reset", m_hlw, 16);
    run(400, 0);
  endtask

  task automatic t_defaults();
    drive_cfg(432, 64, 75, 106, 172, 380, 1250, 10, 62, 576);
    do_reset();
    run(40700, 0);
    chk(first_act == 39916, "R7 first active clock of full-size frame", first_act, 39916);
  endtask

  initial begin
    t_reset();
    t_small_frames();
    t_odd_frame_stall();
    t_cfg_ignore();
    t_defaults();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule